// File: doc/BRIEF.md
# Funnel Shifter with Rotate

This block is a purely combinational shifter for a word of `WIDTH` bits (32 by default). Its core is one right-shifting funnel: it joins an upper half and a lower half into a word of twice the width, moves that word right by a count from 0 up to and including `WIDTH`, and returns the lowest `WIDTH` bits as the result. The core only ever shifts right. Every supported operation is reduced to choosing what goes into the two halves and which count is applied.

A small selection stage in front of the core turns a 2-bit operation code, the operand and a shift count from 0 to `WIDTH-1` into the two halves and the funnel count. A logical right shift puts zeros in the upper half. An arithmetic right shift fills the upper half with the operand's sign bit. A rotate right puts the operand in both halves. A logical left shift puts the operand in the upper half and zeros in the lower half, and shifts right by `WIDTH` minus the count.

The funnel itself is a chain of 2:1 multiplexer levels. Each level either moves the data by one power of two or passes it through. An extra top level chooses the upper half outright when the funnel count equals `WIDTH`. The result has no register and no flags, so a host datapath places the block between its own pipeline registers.

Top module: `funnel_shifter`

## Requirements
- R1: With `op_sel` = 2'b00 (logical right), `result` equals `operand_a` shifted right by `shamt`, with zeros entering from the most significant end.
- R2: With `op_sel` = 2'b01 (arithmetic right), `result` equals `operand_a` shifted right by `shamt`, with copies of `operand_a[WIDTH-1]` entering from the most significant end.
- R3: With `op_sel` = 2'b10 (rotate right), bit j of `result` equals bit (j + `shamt`) mod `WIDTH` of `operand_a`, so the number of set bits is preserved.
- R4: With `op_sel` = 2'b11 (logical left), `result` equals `operand_a` shifted left by `shamt`, with zeros entering at bit 0.
- R5: For every operation code, `shamt` = 0 gives `result` equal to `operand_a`. For the left shift this goes through a funnel count equal to `WIDTH`.
- R6: With `shamt` = `WIDTH-1`, a logical right shift leaves only the old most significant bit at bit 0, and an arithmetic right shift gives all bits equal to the sign bit.
- R7: The funnel returns the low `WIDTH` bits of {upper, lower} shifted right by a count from 0 to `WIDTH`. A count of 0 returns the lower half, a count of `WIDTH` returns the upper half, and multiplexer level k moves the data by 2^k when bit k of the count is set.
- R8: An arithmetic right shift of an operand whose top bit is 0 gives the same result as a logical right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_a | input | WIDTH | Value to be shifted or rotated |
| shamt | input | $clog2(WIDTH) | Shift or rotate count, 0 to WIDTH-1 |
| op_sel | input | 2 | Operation code: 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| result | output | WIDTH | Shifted or rotated value |

## Verification
The hardest case to reach is the top funnel level taking the upper half whole. A user never asks for a shift of `WIDTH`, so this level is set only by a left shift with a count of zero, and an error there can look like a correct pass-through. The stimulus sweeps every count for every operation code over fixed corner operands and pseudo-random operands. It adds dedicated zero-count checks for the left shift and checks with count `WIDTH-1`, so both the top level and the deepest single-step moves are exercised with operands whose two halves differ.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  typedef enum logic [1:0] {
    OP_SRL = 2'b00,
    OP_SRA = 2'b01,
    OP_ROR = 2'b10,
    OP_SLL = 2'b11
  } shift_op_e;

endpackage

// File: rtl/funnel_mux_level.sv
// One 2:1 multiplexer level of the funnel: moves the window by SHIFT or passes it.
module funnel_mux_level #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 4,
  parameter int SHIFT = 4
) (
  input  logic [IN_W-1:0]  din,
  input  logic             sel,
  output logic [OUT_W-1:0] dout
);

  always_comb begin
    if (sel) dout = din[SHIFT +: OUT_W];
    else     dout = din[OUT_W-1:0];
  end

endmodule

// File: rtl/funnel_ctrl.sv
// Turns an operation code into the two funnel halves and the funnel count.
module funnel_ctrl
  import funnel_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [AW-1:0]    shamt,
  input  shift_op_e        op,
  output logic [WIDTH-1:0] upper,
  output logic [WIDTH-1:0] lower,
  output logic [AW:0]      amount
);

  localparam logic [AW:0] FULL_AMT = (AW+1)'(WIDTH);

  function automatic logic [WIDTH-1:0] pick_upper(shift_op_e o, logic [WIDTH-1:0] v);
    case (o)
      OP_SRL:  return '0;
      OP_SRA:  return {WIDTH{v[WIDTH-1]}};
      default: return v;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] pick_lower(shift_op_e o, logic [WIDTH-1:0] v);
    if (o == OP_SLL) return '0;
    return v;
  endfunction

  function automatic logic [AW:0] pick_amount(shift_op_e o, logic [AW-1:0] s);
    if (o == OP_SLL) return FULL_AMT - {1'b0, s};
    return {1'b0, s};
  endfunction

  always_comb begin
    upper  = pick_upper(op, a);
    lower  = pick_lower(op, a);
    amount = pick_amount(op, shamt);
  end

  // The funnel count never exceeds the word width.
  always_comb begin
    assert_amount_range_R7: assert (amount <= FULL_AMT)
      else $error("funnel count above width");
  end

endmodule

// File: rtl/funnel_core.sv
// Right-shift-and-extract array over {y_in, x_in}; count 0..WIDTH.
module funnel_core #(
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] y_in,
  input  logic [WIDTH-1:0] x_in,
  input  logic [AW:0]      amount,
  output logic [WIDTH-1:0] window
);

  localparam logic [AW:0] FULL_AMT = (AW+1)'(WIDTH);
  localparam int TOP_W = 2*WIDTH - 1;

  // Top level: a count of WIDTH takes the upper half outright; the rest of the
  // count is then zero, so the padding bits are never selected.
  logic [TOP_W-1:0] top_out;
  logic             take_upper;

  assign take_upper = amount[AW];

  always_comb begin
    if (take_upper) top_out = {{(WIDTH-1){1'b0}}, y_in};
    else            top_out = {y_in[WIDTH-2:0], x_in};
  end

  // Binary levels from the largest step down; each level keeps only the bits
  // the smaller steps below it can still reach.
  for (genvar k = AW-1; k >= 0; k--) begin : g_lvl
    localparam int SH = 1 << k;
    logic [WIDTH+2*SH-2:0] din;
    logic [WIDTH+SH-2:0]   dout;
    if (k == AW-1) begin : g_first
      assign din = top_out;
    end else begin : g_next
      assign din = g_lvl[k+1].dout;
    end
    funnel_mux_level #(
      .IN_W (WIDTH + 2*SH - 1),
      .OUT_W(WIDTH + SH - 1),
      .SHIFT(SH)
    ) u_mux (
      .din (din),
      .sel (amount[k]),
      .dout(dout)
    );
  end

  assign window = g_lvl[0].dout;

  always_comb begin
    if (amount == FULL_AMT)
      assert_full_takes_upper_R7: assert (window == y_in)
        else $error("count of width did not yield upper half");
    if (amount == '0)
      assert_zero_takes_lower_R7: assert (window == x_in)
        else $error("count of zero did not yield lower half");
  end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import funnel_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_a,
  input  logic [AW-1:0]    shamt,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result
);

  shift_op_e        op;
  logic [WIDTH-1:0] half_upper;
  logic [WIDTH-1:0] half_lower;
  logic [AW:0]      funnel_amt;

  assign op = shift_op_e'(op_sel);

  funnel_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .a     (operand_a),
    .shamt (shamt),
    .op    (op),
    .upper (half_upper),
    .lower (half_lower),
    .amount(funnel_amt)
  );

  funnel_core #(.WIDTH(WIDTH)) u_core (
    .y_in  (half_upper),
    .x_in  (half_lower),
    .amount(funnel_amt),
    .window(result)
  );

  // Observation wires for the port-level checks.
  logic [WIDTH-1:0] low_mask;
  logic             zero_count;
  int               vacated_from;

  assign low_mask     = (WIDTH'(1) << shamt) - WIDTH'(1);
  assign zero_count   = (shamt == '0);
  assign vacated_from = WIDTH - int'(shamt);

  always_comb begin
    if (zero_count)
      assert_zero_count_identity_R5: assert (result == operand_a)
        else $error("zero count changed operand");
    if (op == OP_SRL && !zero_count)
      assert_srl_zero_fill_R1: assert ((result >> vacated_from) == '0)
        else $error("logical right shift filled non-zero");
    if (op == OP_SRA && !zero_count && operand_a[WIDTH-1])
      assert_sra_sign_fill_R2: assert (((~result) >> vacated_from) == '0)
        else $error("arithmetic right shift lost sign fill");
    if (op == OP_ROR)
      assert_ror_keeps_ones_R3: assert ($countones(result) == $countones(operand_a))
        else $error("rotate changed number of set bits");
    if (op == OP_SLL)
      assert_sll_low_zero_R4: assert ((result & low_mask) == '0)
        else $error("left shift filled non-zero at bottom");
  end

endmodule

// File: tb/funnel_shifter_tb_top.sv
module funnel_shifter_tb_top;

  localparam int W  = 32;
  localparam int AW = $clog2(W);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  operand_a;
  logic [AW-1:0] shamt;
  logic [1:0]    op_sel;
  logic [W-1:0]  result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  funnel_shifter #(.WIDTH(W)) dut_i (
    .operand_a(operand_a),
    .shamt    (shamt),
    .op_sel   (op_sel),
    .result   (result)
  );

  // Independent reference, written arithmetically per requirement.
  function automatic logic [W-1:0] model(logic [1:0] o, logic [W-1:0] a, int s);
    logic [2*W-1:0] wide;
    case (o)
      2'b00: return a >> s;                                 // R1
      2'b01: return W'($signed(a) >>> s);                   // R2
      2'b10: begin                                           // R3
        wide = {a, a} >> s;
        return wide[W-1:0];
      end
      default: return a << s;                               // R4
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h sh=%0d: got %h expected %h",
               req, op_sel, operand_a, shamt, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] o, logic [W-1:0] a, int s);
    @(posedge clk);
    op_sel    = o;
    operand_a = a;
    shamt     = AW'(s);
    @(negedge clk);
  endtask

  function automatic string req_of(logic [1:0] o);
    case (o)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  logic [W-1:0] corners [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                                32'h0000_0001, 32'hA5A5_5A5A, 32'h7FFF_FFFF,
                                32'h8765_4321, 32'h0123_4567};

  initial begin
    logic [W-1:0] lfsr;
    logic [W-1:0] srl_v;
    op_sel = 2'b00; operand_a = '0; shamt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state: zero operand, zero count.
    check("R5", result, '0);

    // R1..R4, R7: every count, every operation, corner operands.
    for (int c = 0; c < 8; c++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < W; s++) begin
          apply(2'(o), corners[c], s);
          check(req_of(2'(o)), result, model(2'(o), corners[c], s));
        end

    // R1..R4, R7: pseudo-random operands over every count.
    lfsr = 32'hC0DE_1234;
    for (int n = 0; n < 16; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < W; s++) begin
          apply(2'(o), lfsr, s);
          check(req_of(2'(o)), result, model(2'(o), lfsr, s));
        end
    end

    // R5 and R7: zero count is identity; left shift uses the full funnel count.
    for (int o = 0; o < 4; o++) begin
      apply(2'(o), 32'hDEAD_BEEF, 0);
      check("R5", result, 32'hDEAD_BEEF);
    end
    apply(2'b11, 32'h1234_5678, 0);
    check("R7", result, 32'h1234_5678);

    // R6: count of WIDTH-1.
    apply(2'b00, 32'h8000_0000, W-1);
    check("R6", result, 32'h0000_0001);
    apply(2'b00, 32'h7FFF_FFFF, W-1);
    check("R6", result, 32'h0000_0000);
    apply(2'b01, 32'h8000_0000, W-1);
    check("R6", result, 32'hFFFF_FFFF);
    apply(2'b01, 32'h7FFF_FFFF, W-1);
    check("R6", result, 32'h0000_0000);

    // R8: arithmetic equals logical when the sign bit is clear.
    for (int s = 0; s < W; s++) begin
      apply(2'b00, 32'h6C3A_91F5, s);
      srl_v = result;
      apply(2'b01, 32'h6C3A_91F5, s);
      check("R8", result, srl_v);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

endmodule